// File: doc/BRIEF.md
# Windowed Watchdog Timer with Lock-After-First-Write Configuration

The block is a 12-bit down-counting watchdog driven by a slow-clock tick enable. Software programs a mode register once after reset; that first write fixes the reload value, the restart window, the fault responses and the halt options. Any later write to it is dropped. An accepted mode write also starts a fresh period by loading the counter with the new reload value.

Software services the watchdog by writing the restart bit of the control register. A restart is honoured only when the counter has fallen to or below the programmed window limit. An early restart does not reload the counter and is recorded as an error fault. An underflow (a tick while the count is zero) is also a fault, and it reloads the counter. Faults set sticky status bits that clear when the status register is read. Faults drive a level interrupt and a one-cycle reset request. The request goes either to the processor alone or to the whole system.

Top module: `wdog_window`

## Requirements
- R1: The mode register (address 1) stores only the first write after reset. Later writes leave it unchanged. Reads return the stored value, with bits 31:30 always reading 0.
- R2: Mode layout: reload value in bits 11:0, interrupt enable in bit 12, reset enable in bit 13, processor-only reset select in bit 14, disable in bit 15, window limit in bits 27:16, debug halt in bit 28, idle halt in bit 29. Each tick while running decrements the counter by one. A tick while the count is 0 is an underflow: it reloads the reload value and sets status bit 0.
- R3: Writing bit 0 = 1 to the control register (address 0) while the count is at or below the window limit reloads the counter with the reload value.
- R4: The same restart while the count is above the window limit leaves the count unchanged and sets status bit 1 (error).
- R5: Status bits (address 2) are sticky and clear on a read of the status register. A fault in the same cycle as that read stays set.
- R6: The interrupt output is high while any status bit is set and the interrupt enable is 1. It stays low when the interrupt enable is 0.
- R7: With reset enable = 1, each fault gives a one-cycle pulse on the processor reset request when the processor-only select is 1, or on the system reset request when it is 0. With reset enable = 0, no reset request is raised.
- R8: With debug halt = 1 the counter holds while the debug input is high. With idle halt = 1 it holds while the idle input is high.
- R9: With disable = 1 the counter holds, no faults occur, and restart writes are ignored.
- R10: After reset the mode reads 0x0FFF0FFF, the counter holds 0xFFF, the status is 0, and the interrupt and both reset requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears status) |
| addr | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick | input | 1 | Slow-clock tick enable, one clk cycle wide |
| dbg_state | input | 1 | Processor is in debug state |
| idle_state | input | 1 | System is idle |
| irq | output | 1 | Fault interrupt |
| rst_cpu_req | output | 1 | One-cycle processor reset request |
| rst_all_req | output | 1 | One-cycle system reset request |

## Verification
The window check is driven by a vector table. Each vector sets a reload value and a window limit, then applies a chosen number of ticks before a restart. The vectors land the count one above the limit, exactly on it, well inside it, at zero, and just after an underflow. Together they separate an off-by-one in the window compare from an error in reload or underflow handling. Directed sequences then cover the lock, the halt inputs with and without their enables, the disable bit, and the routing of the reset request. These sequences show that a frozen or disabled counter stays silent, and that each reset request pulses for exactly one cycle.

// File: rtl/wdog_pkg.sv
// Shared widths, register addresses and mode-register layout for the
// windowed watchdog. Assumes a 32-bit register port.
package wdog_pkg;
    localparam int DW    = 32;
    localparam int CNT_W = 12;
    localparam int AW    = 2;

    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_MODE = 2'd1;
    localparam logic [AW-1:0] A_STAT = 2'd2;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic             idle_halt;
        logic             dbg_halt;
        logic [CNT_W-1:0] delta;
        logic             wd_off;
        logic             rst_cpu;
        logic             rst_en;
        logic             irq_en;
        logic [CNT_W-1:0] reload;
    } mode_t;

    localparam logic [DW-1:0] RSVD_MASK    = 32'h3FFF_FFFF;
    localparam logic [DW-1:0] MODE_DEFAULT = 32'h0FFF_0FFF;
endpackage

// File: rtl/wdog_cfg.sv
// Write-once mode register. The first write after reset is stored and
// locks the register; later writes are dropped. Reserved bits are stored as 0.
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_mode,
    input  logic [DW-1:0]       wdata,
    output mode_t               mode,
    output logic                load,
    output logic [CNT_W-1:0]    load_val
);
    logic locked;

    assign load     = wr_mode && !locked;
    assign load_val = wdata[CNT_W-1:0];

    // Capture the first mode write and set the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= mode_t'(MODE_DEFAULT);
            locked <= 1'b0;
        end else if (load) begin
            mode   <= mode_t'(wdata & RSVD_MASK);
            locked <= 1'b1;
        end
    end

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode)); // R1
endmodule

// File: rtl/wdog_counter.sv
// Down counter with restart window. Produces underflow and error events.
// Assumes tick is one clk cycle wide. A restart in the same cycle as a tick wins.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart_req,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic [W-1:0]  reload,
    input  logic [W-1:0]  delta,
    input  logic          wd_off,
    input  logic          dbg_halt,
    input  logic          idle_halt,
    input  logic          dbg_state,
    input  logic          idle_state,
    output logic          uf_evt,
    output logic          err_evt
);
    localparam logic [W-1:0] CNT_INIT = '1;

    logic [W-1:0] cnt;
    logic active, halted, in_window, restart_ok, step;

    // Qualify ticks and restarts against the current mode and count.
    always_comb begin
        active     = !wd_off;
        halted     = (dbg_halt && dbg_state) || (idle_halt && idle_state);
        in_window  = (cnt <= delta);
        restart_ok = restart_req && active && in_window;
        err_evt    = restart_req && active && !in_window;
        step       = tick && active && !halted;
        uf_evt     = step && (cnt == '0) && !restart_ok;
    end

    // Count down, reload on config load, accepted restart or underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_INIT;
        end else if (load) begin
            cnt <= load_val;
        end else if (restart_ok) begin
            cnt <= reload;
        end else if (step) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_ok && !load) |=> (cnt == $past(reload))); // R3
    AST_EARLY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt && !step && !load) |=> (cnt == $past(cnt))); // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && halted && !restart_ok && !load) |=> $stable(cnt)); // R8
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> $stable(cnt)); // R9
endmodule

// File: rtl/wdog_fault.sv
// Sticky fault status, interrupt gating and one-cycle reset request pulses.
// Assumes a status read and a new fault in the same cycle keep the new fault.
module wdog_fault (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uf_evt,
    input  logic       err_evt,
    input  logic       clr,
    input  logic       irq_en,
    input  logic       rst_en,
    input  logic       rst_cpu,
    output logic [1:0] status,
    output logic       irq,
    output logic       rst_cpu_req,
    output logic       rst_all_req
);
    logic fault;

    assign fault = uf_evt || err_evt;
    assign irq   = irq_en && (status != 2'b00);

    // Hold fault flags until a status read; new events override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 2'b00;
        end else begin
            status <= (clr ? 2'b00 : status) | {err_evt, uf_evt};
        end
    end

    // Route each fault into a single-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_cpu_req <= 1'b0;
            rst_all_req <= 1'b0;
        end else begin
            rst_cpu_req <= fault && rst_en && rst_cpu;
            rst_all_req <= fault && rst_en && !rst_cpu;
        end
    end

    AST_ONE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_cpu_req, rst_all_req})); // R7
    AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> status[0]); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> status[1]); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !uf_evt && !err_evt) |=> (status == 2'b00)); // R5
endmodule

// File: rtl/wdog_window.sv
// Top of the windowed watchdog: register decode, write-once mode register,
// windowed down counter and fault handling. Assumes single-cycle accesses.
module wdog_window
    import wdog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic          tick,
    input  logic          dbg_state,
    input  logic          idle_state,
    output logic          irq,
    output logic          rst_cpu_req,
    output logic          rst_all_req
);
    mode_t            mode;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             uf_evt, err_evt;
    logic [1:0]       status;
    logic             wr_mode, restart_req, clr;

    assign wr_mode     = wr_en && (addr == A_MODE);
    assign restart_req = wr_en && (addr == A_CTRL) && wdata[0];
    assign clr         = rd_en && (addr == A_STAT);

    // Read mux: control reads as zero, mode and status as stored.
    always_comb begin
        case (addr)
            A_MODE:  rdata = DW'(mode);
            A_STAT:  rdata = {{(DW-2){1'b0}}, status};
            default: rdata = '0;
        endcase
    end

    wdog_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wdata(wdata),
        .mode(mode), .load(load), .load_val(load_val)
    );

    wdog_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart_req(restart_req),
        .load(load), .load_val(load_val), .reload(mode.reload),
        .delta(mode.delta), .wd_off(mode.wd_off), .dbg_halt(mode.dbg_halt),
        .idle_halt(mode.idle_halt), .dbg_state(dbg_state),
        .idle_state(idle_state), .uf_evt(uf_evt), .err_evt(err_evt)
    );

    wdog_fault u_flt (
        .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .err_evt(err_evt),
        .clr(clr), .irq_en(mode.irq_en), .rst_en(mode.rst_en),
        .rst_cpu(mode.rst_cpu), .status(status), .irq(irq),
        .rst_cpu_req(rst_cpu_req), .rst_all_req(rst_all_req)
    );
endmodule

// File: tb/sim_wdog_window.sv
module sim_wdog_window;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0, dbg_state = 1'b0, idle_state = 1'b0;
    logic        irq, rst_cpu_req, rst_all_req;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic p_cpu, p_all;

    wdog_window u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .dbg_state(dbg_state),
        .idle_state(idle_state), .irq(irq), .rst_cpu_req(rst_cpu_req),
        .rst_all_req(rst_all_req)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [11:0] wdv;
        logic [11:0] wdd;
        logic [11:0] n;
        logic [1:0]  st;
    } vec_t;

    // reload, window limit, ticks before restart, expected status (R3 R4)
    localparam vec_t VECS [8] = '{
        '{12'd20, 12'd10, 12'd9,  2'b10},
        '{12'd20, 12'd10, 12'd10, 2'b00},
        '{12'd20, 12'd10, 12'd15, 2'b00},
        '{12'd8,  12'd8,  12'd0,  2'b00},
        '{12'd8,  12'd0,  12'd7,  2'b10},
        '{12'd8,  12'd0,  12'd8,  2'b00},
        '{12'd5,  12'd5,  12'd6,  2'b01},
        '{12'd6,  12'hFFF, 12'd0, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        dbg_state = 1'b0; idle_state = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
        p_cpu = rst_cpu_req; p_all = rst_all_req;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            p_cpu = rst_cpu_req; p_all = rst_all_req;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;

        // Window vectors, each from a fresh reset
        for (int v = 0; v < 8; v++) begin
            do_reset();
            wr(2'd1, {4'h0, VECS[v].wdd, 4'h3, VECS[v].wdv});
            ticks(int'(VECS[v].n));
            wr(2'd0, 32'h1);
            rd(2'd2, r);
            chk($sformatf("R3/R4 vector %0d status", v), r, {30'd0, VECS[v].st});
        end

        // R10 reset state
        do_reset();
        #1;
        chk("R10 irq", {31'd0, irq}, 32'd0);
        chk("R10 rst reqs", {30'd0, rst_cpu_req, rst_all_req}, 32'd0);
        rd(2'd1, r); chk("R10 mode", r, 32'h0FFF_0FFF);
        rd(2'd2, r); chk("R10 status", r, 32'd0);

        // R1 write once, reserved bits read 0
        wr(2'd1, 32'hC003_100A);
        rd(2'd1, r); chk("R1 first write", r, 32'h0003_100A);
        wr(2'd1, 32'h0000_0001);
        rd(2'd1, r); chk("R1 second write dropped", r, 32'h0003_100A);

        // R2 underflow, R6 interrupt, R5 read clears
        ticks(10);
        chk("R6 irq low before fault", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R6 irq on underflow", {31'd0, irq}, 32'd1);
        rd(2'd2, r); chk("R2 underflow status", r, 32'd1);
        rd(2'd2, r); chk("R5 cleared by read", r, 32'd0);
        chk("R6 irq low after clear", {31'd0, irq}, 32'd0);

        // R3 restart inside window reloads
        ticks(7);
        wr(2'd0, 32'h1);
        ticks(10);
        rd(2'd2, r); chk("R3 no fault after reload", r, 32'd0);
        ticks(1);
        rd(2'd2, r); chk("R3 underflow after full period", r, 32'd1);

        // R4 early restart: error and no reload
        wr(2'd0, 32'h1);
        rd(2'd2, r); chk("R4 error status", r, 32'd2);
        ticks(10);
        rd(2'd2, r); chk("R4 count kept", r, 32'd0);
        ticks(1);
        rd(2'd2, r); chk("R4 underflow on old count", r, 32'd1);

        // R7 processor reset route, irq disabled
        do_reset();
        wr(2'd1, 32'h0000_6002);
        ticks(3);
        chk("R7 cpu pulse", {30'd0, p_cpu, p_all}, 32'd2);
        chk("R6 irq off when disabled", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 pulse one cycle", {30'd0, rst_cpu_req, rst_all_req}, 32'd0);

        // R7 system reset route, on error fault
        do_reset();
        wr(2'd1, 32'h0000_2002);
        wr(2'd0, 32'h1);
        chk("R7 all pulse on error", {30'd0, p_cpu, p_all}, 32'd1);

        // R7 reset disabled
        do_reset();
        wr(2'd1, 32'h0000_0002);
        ticks(3);
        chk("R7 no request", {30'd0, p_cpu, p_all}, 32'd0);

        // R8 debug halt
        do_reset();
        wr(2'd1, 32'h1FFF_0003);
        dbg_state = 1'b1;
        ticks(10);
        rd(2'd2, r); chk("R8 debug halt holds", r, 32'd0);
        dbg_state = 1'b0; idle_state = 1'b1;
        ticks(3);
        rd(2'd2, r); chk("R8 idle ignored without enable", r, 32'd0);
        ticks(1);
        rd(2'd2, r); chk("R8 counts when not halted", r, 32'd1);

        // R8 idle halt
        do_reset();
        wr(2'd1, 32'h2FFF_0003);
        idle_state = 1'b1;
        ticks(10);
        rd(2'd2, r); chk("R8 idle halt holds", r, 32'd0);
        idle_state = 1'b0;
        ticks(4);
        rd(2'd2, r); chk("R8 resumes after idle", r, 32'd1);

        // R9 disabled: no count, no fault, restart ignored
        do_reset();
        wr(2'd1, 32'h0000_B003);
        ticks(10);
        chk("R9 no pulse", {30'd0, p_cpu, p_all}, 32'd0);
        wr(2'd0, 32'h1);
        rd(2'd2, r); chk("R9 no fault", r, 32'd0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule